// File: doc/BRIEF.md
# Flash Write Protection Gate

This block sits between a host's asynchronous-style flash control strobes and a flash command interface. It decides two things. The first is whether a completed bus write may be passed on as a command strobe. The second is whether a program or erase is permitted on the sector that is currently addressed. It samples chip-select, output-enable and write-strobe on the system clock. Each strobe goes through a stable-for-N-samples glitch filter. A write is accepted as a one-clock pulse on the filtered rising edge of the write strobe.

Several lockout sources are merged:
- a low-supply flag, which also requests a return to read-array mode;
- a device reset input;
- a power-up guard that swallows a write strobe that was already held low when the block came out of reset;
- a pin that locks the two boot sectors, which sit at the bottom or the top of the array depending on a configuration bit;
- a pin that locks the whole array;
- a per-sector protection register loaded in parallel.

All pins are plain control and status signals. No data stream crosses the block, so it has no valid/ready handshake and applies no back-pressure. The strobe inputs are assumed to be already synchronous to `clk`.

Top module: `flash_wr_gate`

## Requirements
- R1: After a clock in which the filtered chip_sel_n is low, the filtered wr_strobe_n is low and the filtered rd_en_n is high, the filtered rising edge of wr_strobe_n produces a wr_accept pulse exactly one clock wide. The pulse is seen after the (GLITCH_CYC+1)-th rising clock edge, counting the first edge that samples wr_strobe_n high as edge 0.
- R2: No wr_accept is produced when, during the write phase, rd_en_n is low or chip_sel_n is high.
- R3: A level change on any strobe that lasts fewer than GLITCH_CYC consecutive clock samples is ignored. It neither starts a write nor breaks one that is in progress.
- R4: While supply_low is high, no write is accepted. A write phase that sees supply_low high at any point never produces wr_accept. force_read follows supply_low with one clock of delay.
- R5: Suppose that, on the first clock after rst_n is released, wr_strobe_n, chip_sel_n and hold_rst_n are low and rd_en_n is high. Then the next filtered rising edge of wr_strobe_n produces no wr_accept. Later writes are accepted normally.
- R6: While hold_rst_n is low, no wr_accept is produced.
- R7: sector_ok is registered every clock. It is 1 only when sector_idx is in range, the stored protection bit for that sector is 0, and neither lock pin blocks the sector. prot_load high loads prot_data, with bit i protecting sector i (1 = protected). The stored protection bits reset to all zero.
- R8: With boot_guard_n low and top_boot 0, sectors 0 and 1 give sector_ok 0.
- R9: With boot_guard_n low and top_boot 1, sectors NUM_SECTORS-2 and NUM_SECTORS-1 give sector_ok 0 (132 and 133 at the default size). With boot_guard_n high, these boot sectors follow their stored bits.
- R10: With bulk_lock_n low, sector_ok is 0 for every sector.
- R11: A sector_idx of NUM_SECTORS or more gives sector_ok 0.
- R12: During reset, wr_accept, sector_ok and force_read are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset (power-up) |
| chip_sel_n | input | 1 | Chip select strobe, active low |
| rd_en_n | input | 1 | Output-enable strobe, active low |
| wr_strobe_n | input | 1 | Write strobe, active low |
| boot_guard_n | input | 1 | Low locks the two boot sectors |
| bulk_lock_n | input | 1 | Low locks every sector |
| hold_rst_n | input | 1 | Device reset input, low blocks writes |
| supply_low | input | 1 | Supply below lockout level |
| top_boot | input | 1 | 1 = boot sectors at the top of the array, 0 = at the bottom |
| sector_idx | input | SEC_W | Target sector index |
| prot_load | input | 1 | Parallel-load enable for the protection bits |
| prot_data | input | NUM_SECTORS | Protection bits to load (1 = protected) |
| wr_accept | output | 1 | One-clock accepted write pulse |
| sector_ok | output | 1 | Program or erase allowed on sector_idx |
| force_read | output | 1 | Request to return to read-array mode |

## Verification
The bench builds the block with the default 134 sectors, so the top boot pair sits at 132 and 133 and index 134 is the first out-of-range value. It raises GLITCH_CYC to 3 so that both one-sample and two-sample strobe pulses can be shown to be rejected, and the latency of accepted writes is checked at that depth. Random lock settings, random protection vectors and random sectors are mixed with directed cases for the boot pair at both ends and for each inhibiting condition.

// File: rtl/fwg_pkg.sv
package fwg_pkg;

  // power-up guard states
  typedef enum logic [1:0] {
    PU_EVAL = 2'd0,
    PU_HOLD = 2'd1,
    PU_DONE = 2'd2
  } pu_state_t;

  // strobe bundle, bit order used by the filter bank
  typedef struct packed {
    logic cs_n;
    logic rd_n;
    logic wr_n;
  } strobes_t;

  localparam int NUM_STROBES = 3;

endpackage

// File: rtl/fwg_strobe_filter.sv
module fwg_strobe_filter #(
  parameter int GLITCH_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic filt
);

  generate
    if (GLITCH_CYC <= 1) begin : g_direct
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) filt <= 1'b1;
        else        filt <= raw;
      end
    end else begin : g_count
      localparam int CW = $clog2(GLITCH_CYC);
      logic [CW-1:0] cnt;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          filt <= 1'b1;
          cnt  <= '0;
        end else if (raw != filt) begin
          if (cnt == CW'(GLITCH_CYC - 1)) begin
            filt <= raw;
            cnt  <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end else begin
          cnt <= '0;
        end
      end
    end
  endgenerate

endmodule

// File: rtl/fwg_powerup_guard.sv
module fwg_powerup_guard
  import fwg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n_raw,
  input  logic rd_n_raw,
  input  logic wr_n_raw,
  input  logic hold_rst_n,
  input  logic we_rise,
  output logic pu_done
);

  pu_state_t state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= PU_EVAL;
    end else begin
      unique case (state)
        PU_EVAL: begin
          if (!wr_n_raw && !cs_n_raw && !hold_rst_n && rd_n_raw) state <= PU_HOLD;
          else                                                   state <= PU_DONE;
        end
        PU_HOLD: if (we_rise) state <= PU_DONE;
        default: state <= PU_DONE;
      endcase
    end
  end

  assign pu_done = (state == PU_DONE);

endmodule

// File: rtl/fwg_sector_lock.sv
module fwg_sector_lock #(
  parameter int NUM_SECTORS = 134,
  parameter int SEC_W       = 9
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   prot_load,
  input  logic [NUM_SECTORS-1:0] prot_data,
  input  logic                   boot_guard_n,
  input  logic                   bulk_lock_n,
  input  logic                   top_boot,
  input  logic [SEC_W-1:0]       sector_idx,
  output logic                   allowed
);

  localparam int IW = $clog2(NUM_SECTORS);

  logic [NUM_SECTORS-1:0] prot_q;
  logic in_range, boot_hit, stored;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         prot_q <= '0;
    else if (prot_load) prot_q <= prot_data;
  end

  always_comb begin
    in_range = (int'(sector_idx) < NUM_SECTORS);
    if (top_boot) boot_hit = in_range && (int'(sector_idx) >= NUM_SECTORS - 2);
    else          boot_hit = (int'(sector_idx) < 2);
    stored  = in_range ? prot_q[sector_idx[IW-1:0]] : 1'b1;
    allowed = in_range && bulk_lock_n && !stored && !(!boot_guard_n && boot_hit);
  end

endmodule

// File: rtl/flash_wr_gate.sv
module flash_wr_gate
  import fwg_pkg::*;
#(
  parameter int NUM_SECTORS = 134,
  parameter int GLITCH_CYC  = 2,
  localparam int SEC_W      = $clog2(NUM_SECTORS) + 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   chip_sel_n,
  input  logic                   rd_en_n,
  input  logic                   wr_strobe_n,
  input  logic                   boot_guard_n,
  input  logic                   bulk_lock_n,
  input  logic                   hold_rst_n,
  input  logic                   supply_low,
  input  logic                   top_boot,
  input  logic [SEC_W-1:0]       sector_idx,
  input  logic                   prot_load,
  input  logic [NUM_SECTORS-1:0] prot_data,
  output logic                   wr_accept,
  output logic                   sector_ok,
  output logic                   force_read
);

  strobes_t raw_s, filt_s;
  logic we_d, act_d, armed;
  logic active, we_rise, armed_nxt, accept_c;
  logic pu_done, allowed;

  assign raw_s = '{cs_n: chip_sel_n, rd_n: rd_en_n, wr_n: wr_strobe_n};

  // one filter per strobe
  generate
    for (genvar i = 0; i < NUM_STROBES; i++) begin : g_filt
      fwg_strobe_filter #(.GLITCH_CYC(GLITCH_CYC)) u_filt (
        .clk  (clk),
        .rst_n(rst_n),
        .raw  (raw_s[i]),
        .filt (filt_s[i])
      );
    end
  endgenerate

  assign active    = !filt_s.cs_n && !filt_s.wr_n && filt_s.rd_n;
  assign we_rise   = filt_s.wr_n && !we_d;
  // a write phase arms only if it begins and continues with good supply
  assign armed_nxt = active && !supply_low && (armed || !act_d);
  assign accept_c  = we_rise && armed && !supply_low && pu_done && hold_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_d       <= 1'b1;
      act_d      <= 1'b0;
      armed      <= 1'b0;
      wr_accept  <= 1'b0;
      sector_ok  <= 1'b0;
      force_read <= 1'b0;
    end else begin
      we_d       <= filt_s.wr_n;
      act_d      <= active;
      armed      <= armed_nxt;
      wr_accept  <= accept_c;
      sector_ok  <= allowed;
      force_read <= supply_low;
    end
  end

  fwg_powerup_guard u_pu (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n_raw  (chip_sel_n),
    .rd_n_raw  (rd_en_n),
    .wr_n_raw  (wr_strobe_n),
    .hold_rst_n(hold_rst_n),
    .we_rise   (we_rise),
    .pu_done   (pu_done)
  );

  fwg_sector_lock #(.NUM_SECTORS(NUM_SECTORS), .SEC_W(SEC_W)) u_lock (
    .clk         (clk),
    .rst_n       (rst_n),
    .prot_load   (prot_load),
    .prot_data   (prot_data),
    .boot_guard_n(boot_guard_n),
    .bulk_lock_n (bulk_lock_n),
    .top_boot    (top_boot),
    .sector_idx  (sector_idx),
    .allowed     (allowed)
  );

endmodule

// File: rtl/flash_wr_gate_chk.sv
module flash_wr_gate_chk #(
  parameter int NUM_SECTORS = 134,
  parameter int SEC_W       = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             supply_low,
  input logic             hold_rst_n,
  input logic             bulk_lock_n,
  input logic [SEC_W-1:0] sector_idx,
  input logic             wr_accept,
  input logic             sector_ok,
  input logic             force_read
);

  // R1
  accept_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_accept |=> !wr_accept);

  // R4
  supply_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    supply_low |=> !wr_accept);

  // R4
  force_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    supply_low |=> force_read);

  // R4
  force_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_low |=> !force_read);

  // R6
  hold_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_rst_n |=> !wr_accept);

  // R10
  bulk_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bulk_lock_n |=> !sector_ok);

  // R11
  range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(sector_idx) >= NUM_SECTORS) |=> !sector_ok);

endmodule

bind flash_wr_gate flash_wr_gate_chk #(.NUM_SECTORS(NUM_SECTORS), .SEC_W(SEC_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .supply_low (supply_low),
  .hold_rst_n (hold_rst_n),
  .bulk_lock_n(bulk_lock_n),
  .sector_idx (sector_idx),
  .wr_accept  (wr_accept),
  .sector_ok  (sector_ok),
  .force_read (force_read)
);

// File: tb/test_flash_wr_gate.sv
module test_flash_wr_gate;

  localparam int N  = 134;
  localparam int G  = 3;
  localparam int SW = $clog2(N) + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic chip_sel_n = 1'b1, rd_en_n = 1'b1, wr_strobe_n = 1'b1;
  logic boot_guard_n = 1'b1, bulk_lock_n = 1'b1, hold_rst_n = 1'b1;
  logic supply_low = 1'b0, top_boot = 1'b0;
  logic [SW-1:0] sector_idx = '0;
  logic prot_load = 1'b0;
  logic [N-1:0] prot_data = '0;
  logic [N-1:0] prot_m = '0;
  logic wr_accept, sector_ok, force_read;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  flash_wr_gate #(.NUM_SECTORS(N), .GLITCH_CYC(G)) i_flash_wr_gate (
    .clk(clk), .rst_n(rst_n), .chip_sel_n(chip_sel_n), .rd_en_n(rd_en_n),
    .wr_strobe_n(wr_strobe_n), .boot_guard_n(boot_guard_n), .bulk_lock_n(bulk_lock_n),
    .hold_rst_n(hold_rst_n), .supply_low(supply_low), .top_boot(top_boot),
    .sector_idx(sector_idx), .prot_load(prot_load), .prot_data(prot_data),
    .wr_accept(wr_accept), .sector_ok(sector_ok), .force_read(force_read)
  );

  function automatic logic exp_ok(int idx, logic [N-1:0] p, logic wp_n, logic acc_n, logic top);
    logic boot;
    if (idx >= N) return 1'b0;
    boot = top ? (idx >= N - 2) : (idx < 2);
    return acc_n && !p[idx] && !(!wp_n && boot);
  endfunction

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic load_prot(logic [N-1:0] v);
    prot_data = v;
    prot_load = 1'b1;
    step(1);
    prot_load = 1'b0;
    prot_m = v;
  endtask

  // full write; checks pulse latency, width and the sector flag
  task automatic do_write(bit exp_acc, bit exp_sec, string req);
    chip_sel_n = 1'b0; rd_en_n = 1'b1; wr_strobe_n = 1'b0;
    step(G + 3);
    wr_strobe_n = 1'b1;
    step(G);
    chk({req, " pre-latency"}, wr_accept, 0);
    step(1);
    chk({req, " accept"}, wr_accept, exp_acc);
    if (exp_acc) chk({req, " sector_ok"}, sector_ok, exp_sec);
    step(1);
    chk({req, " pulse width R1"}, wr_accept, 0);
    chip_sel_n = 1'b1;
    step(G + 2);
  endtask

  task automatic count_window(int n, output int cnt);
    cnt = 0;
    for (int i = 0; i < n; i++) begin
      step(1);
      if (wr_accept) cnt++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int cnt;
    logic [N-1:0] v;
    int s;
    step(2);
    // R12 reset state
    chk("R12 wr_accept", wr_accept, 0);
    chk("R12 sector_ok", sector_ok, 0);
    chk("R12 force_read", force_read, 0);
    rst_n = 1'b1;
    step(3);

    // R1 plain write, unprotected sector
    sector_idx = SW'(5);
    do_write(1, 1, "R1 basic");

    // R2 inhibits
    chip_sel_n = 1'b0; rd_en_n = 1'b0; wr_strobe_n = 1'b0;
    step(G + 3); wr_strobe_n = 1'b1;
    count_window(2 * G + 4, cnt);
    chk("R2 rd_en_n low", cnt, 0);
    rd_en_n = 1'b1; chip_sel_n = 1'b1; wr_strobe_n = 1'b0;
    step(G + 3); wr_strobe_n = 1'b1;
    count_window(2 * G + 4, cnt);
    chk("R2 chip_sel_n high", cnt, 0);

    // R3 short wr_strobe_n pulses (1 and G-1 samples)
    for (int w = 1; w < G; w++) begin
      chip_sel_n = 1'b0; rd_en_n = 1'b1; wr_strobe_n = 1'b1;
      step(G + 2);
      wr_strobe_n = 1'b0; step(w); wr_strobe_n = 1'b1;
      count_window(2 * G + 4, cnt);
      chk("R3 short write pulse", cnt, 0);
    end
    chip_sel_n = 1'b1; step(G + 2);
    // R3 chip_sel glitch inside a write is ignored
    chip_sel_n = 1'b0; rd_en_n = 1'b1; wr_strobe_n = 1'b0;
    step(G + 3);
    chip_sel_n = 1'b1; step(G - 1); chip_sel_n = 1'b0;
    step(G + 2);
    wr_strobe_n = 1'b1;
    count_window(2 * G + 4, cnt);
    chk("R3 cs glitch ignored", cnt, 1);
    chip_sel_n = 1'b1; step(G + 2);

    // R4 supply low mid-phase, released before strobe rise
    chip_sel_n = 1'b0; wr_strobe_n = 1'b0;
    step(G + 3);
    supply_low = 1'b1;
    step(1);
    chk("R4 force_read rise", force_read, 1);
    step(2);
    supply_low = 1'b0;
    step(1);
    chk("R4 force_read fall", force_read, 0);
    wr_strobe_n = 1'b1;
    count_window(2 * G + 4, cnt);
    chk("R4 interrupted phase", cnt, 0);
    // R4 supply low across rising strobe
    wr_strobe_n = 1'b0; step(G + 3);
    supply_low = 1'b1; wr_strobe_n = 1'b1;
    count_window(2 * G + 4, cnt);
    chk("R4 low at rise", cnt, 0);
    supply_low = 1'b0; chip_sel_n = 1'b1; step(G + 2);

    // R6 device reset held low
    hold_rst_n = 1'b0;
    chip_sel_n = 1'b0; wr_strobe_n = 1'b0; step(G + 3);
    wr_strobe_n = 1'b1;
    count_window(2 * G + 4, cnt);
    chk("R6 hold_rst_n low", cnt, 0);
    hold_rst_n = 1'b1; chip_sel_n = 1'b1; step(G + 2);

    // R5 power-up with strobes low and device reset low
    rst_n = 1'b0;
    chip_sel_n = 1'b0; rd_en_n = 1'b1; wr_strobe_n = 1'b0; hold_rst_n = 1'b0;
    step(3);
    chk("R12 force_read in reset", force_read, 0);
    rst_n = 1'b1;
    step(1);
    hold_rst_n = 1'b1;
    step(G + 3);
    wr_strobe_n = 1'b1;
    count_window(2 * G + 4, cnt);
    chk("R5 first strobe swallowed", cnt, 0);
    chip_sel_n = 1'b1; step(G + 2);
    do_write(1, 1, "R5 later write");

    // R7 protection register
    v = '0; v[40] = 1'b1;
    load_prot(v);
    sector_idx = SW'(40);
    do_write(1, 0, "R7 stored bit set");
    sector_idx = SW'(41);
    do_write(1, 1, "R7 neighbour clear");

    // R8 / R9 boot pairs
    load_prot('0);
    boot_guard_n = 1'b0; top_boot = 1'b0;
    sector_idx = SW'(0); step(2); chk("R8 bottom 0", sector_ok, 0);
    sector_idx = SW'(1); step(2); chk("R8 bottom 1", sector_ok, 0);
    sector_idx = SW'(N - 1); step(2); chk("R8 top free", sector_ok, 1);
    top_boot = 1'b1;
    sector_idx = SW'(N - 2); step(2); chk("R9 top 132", sector_ok, 0);
    sector_idx = SW'(N - 1); step(2); chk("R9 top 133", sector_ok, 0);
    sector_idx = SW'(0); step(2); chk("R9 bottom free", sector_ok, 1);
    boot_guard_n = 1'b1;
    v = '0; v[N - 1] = 1'b1; load_prot(v);
    sector_idx = SW'(N - 1); step(2); chk("R9 guard high stored", sector_ok, 0);
    sector_idx = SW'(N - 2); step(2); chk("R9 guard high clear", sector_ok, 1);

    // R10 / R11
    bulk_lock_n = 1'b0; sector_idx = SW'(7); step(2);
    chk("R10 bulk lock", sector_ok, 0);
    bulk_lock_n = 1'b1; sector_idx = SW'(N); step(2);
    chk("R11 out of range", sector_ok, 0);

    // random mix R7-R11 through full writes
    for (int it = 0; it < 40; it++) begin
      int sel;
      v = '0;
      for (int b = 0; b < N; b++) v[b] = ($urandom_range(0, 3) == 0);
      load_prot(v);
      boot_guard_n = ($urandom_range(0, 1) == 1);
      bulk_lock_n  = ($urandom_range(0, 4) != 0);
      top_boot     = ($urandom_range(0, 1) == 1);
      sel = $urandom_range(0, 5);
      case (sel)
        0: s = 0;
        1: s = 1;
        2: s = N - 2;
        3: s = N - 1;
        4: s = N + $urandom_range(0, 3);
        default: s = $urandom_range(0, N - 1);
      endcase
      sector_idx = SW'(s);
      do_write(1, exp_ok(s, prot_m, boot_guard_n, bulk_lock_n, top_boot), "R7 random");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0007));
  end

endmodule